// File: doc/BRIEF.md
# Ring Buffer Segment Allocator

This block splits a circular window of external memory into equal, fixed-size segments. It hands the segments to a producer one at a time over a valid/ready request channel. Each accepted request carries the byte address of the first byte of a segment. The allocator walks upward through the window and returns to the bottom when the next whole segment would not fit below the upper bound.

A consumer returns segments with a one-bit release strobe. Each pulse gives back the oldest segment still held. No address travels with it, because segments always come back in the order they were granted. The allocator counts the segments that are out. It withdraws its offer when all segments that fit in the window are held.

The window bounds and an enable arrive as quasi-static inputs. The bounds must be set before enable rises and must then stay fixed. While enable is low the allocator is idle and cleared. The offer appears in the same cycle that enable goes high.

Top module: `seg_ring_alloc`

## Requirements
- R1: While `enable` is low, `req_valid` is low. When `enable` is high, `rst` is low and fewer than the capacity are outstanding, `req_valid` is high in that same cycle.
- R2: After the allocator is cleared, the first granted address equals `region_first`. A grant is a cycle with both `req_valid` and `req_ready` high. Each later grant offers the previous address plus `SEG_BYTES`.
- R3: When the segment after the current one would extend past `region_last`, the next address offered is `region_first`. Any leftover bytes at the top of the window are skipped.
- R4: The capacity is floor((`region_last` - `region_first` + 1) / `SEG_BYTES`). `req_valid` is low while the number of outstanding segments equals the capacity.
- R5: A one-cycle high pulse on `release_pulse` returns one outstanding segment. If the allocator was full, `req_valid` is high again in the next cycle.
- R6: A grant and a release in the same cycle leave the outstanding count unchanged.
- R7: Lowering `enable` for at least one clock edge clears the address pointer to `region_first` and the outstanding count to zero.
- R8: `rst` is synchronous and active-high. It has the same clearing effect as R7, and `req_valid` is low while it is high.
- R9: A release pulse has no effect on `req_addr`; only a grant moves it.
- R10: `SEG_BYTES` is a power of two. Every offered address is `region_first` plus a whole multiple of `SEG_BYTES`, and the last byte of the offered segment does not exceed `region_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allocator active; low clears the allocator |
| region_first | input | ADDR_W | First usable byte address (inclusive) |
| region_last | input | ADDR_W | Last usable byte address (inclusive) |
| req_valid | output | 1 | A segment address is on offer |
| req_ready | input | 1 | The requester takes the offered segment |
| req_addr | output | ADDR_W | Start byte address of the offered segment |
| release_pulse | input | 1 | Returns the oldest outstanding segment |

## Verification
The assertions take three things as given about the inputs:
- The window bounds stay fixed while `enable` is high.
- The window holds at least one segment and has `region_last` not below `region_first`.
- A release is never issued with nothing outstanding.

The stimulus sets the bounds only during reset. The window has room for five segments plus a tail too short for a sixth. The stimulus tracks the outstanding count in its own model and pulses the release line only when that count is above zero. The scoreboard compares every grant against an address predicted from the requirements. It does this across wrap-around, a full window, simultaneous grant and release, and clears caused by both reset and enable.

// File: rtl/seg_alloc_pkg.sv
package seg_alloc_pkg;

    // Update applied to the outstanding-segment counter in one cycle.
    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_INC  = 2'd1,
        OCC_DEC  = 2'd2
    } occ_op_e;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic occ_op_e occ_decide(input logic take, input logic give_back);
        if (take && !give_back) begin
            return OCC_INC;
        end
        if (give_back && !take) begin
            return OCC_DEC;
        end
        return OCC_HOLD;
    endfunction

endpackage

// File: rtl/seg_capacity.sv
module seg_capacity #(
    parameter int ADDR_W    = 28,
    parameter int SEG_SHIFT = 11,
    parameter int CNT_W     = ADDR_W + 1 - SEG_SHIFT
) (
    input  logic [ADDR_W-1:0] region_first,
    input  logic [ADDR_W-1:0] region_last,
    output logic [CNT_W-1:0]  capacity
);
    logic [ADDR_W:0] span;

    always_comb begin
        span     = {1'b0, region_last} - {1'b0, region_first} + {{ADDR_W{1'b0}}, 1'b1};
        capacity = span[ADDR_W:SEG_SHIFT];
    end
endmodule

// File: rtl/seg_pointer.sv
module seg_pointer #(
    parameter int ADDR_W    = 28,
    parameter int SEG_SHIFT = 11,
    parameter int CNT_W     = ADDR_W + 1 - SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              advance,
    input  logic [CNT_W-1:0]  capacity,
    input  logic [ADDR_W-1:0] region_first,
    output logic [ADDR_W-1:0] seg_addr
);
    logic [CNT_W-1:0]  slot_q;
    logic [CNT_W-1:0]  slot_inc;
    logic [CNT_W-1:0]  slot_next;
    logic [ADDR_W:0]   offset;

    always_comb begin
        slot_inc  = slot_q + CNT_W'(1);
        slot_next = (slot_inc >= capacity) ? '0 : slot_inc;
        offset    = {slot_q, {SEG_SHIFT{1'b0}}};
        seg_addr  = region_first + offset[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            slot_q <= '0;
        end else if (advance) begin
            slot_q <= slot_next;
        end
    end
endmodule

// File: rtl/seg_occupancy.sv
module seg_occupancy
    import seg_alloc_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             take,
    input  logic             give_back,
    input  logic [CNT_W-1:0] capacity,
    output logic [CNT_W-1:0] held,
    output logic             full
);
    occ_op_e op;

    always_comb begin
        op   = occ_decide(take, give_back && (held != '0));
        full = (held >= capacity);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            held <= '0;
        end else begin
            unique case (op)
                OCC_INC: held <= held + CNT_W'(1);
                OCC_DEC: held <= held - CNT_W'(1);
                default: held <= held;
            endcase
        end
    end
endmodule

// File: rtl/seg_ring_alloc.sv
module seg_ring_alloc
    import seg_alloc_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int SEG_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] region_first,
    input  logic [ADDR_W-1:0] region_last,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              release_pulse
);
    localparam int SEG_SHIFT = $clog2(SEG_BYTES);
    localparam int CNT_W     = ADDR_W + 1 - SEG_SHIFT;

    initial begin
        if (!is_pow2(SEG_BYTES) || SEG_SHIFT >= ADDR_W) begin
            $error("seg_ring_alloc: SEG_BYTES must be a power of two below 2**ADDR_W");
        end
    end

    logic [CNT_W-1:0] capacity;
    logic [CNT_W-1:0] occ_count;
    logic             occ_full;
    logic             grant;

    assign req_valid = enable && !rst && !occ_full;
    assign grant     = req_valid && req_ready;

    seg_capacity #(
        .ADDR_W   (ADDR_W),
        .SEG_SHIFT(SEG_SHIFT),
        .CNT_W    (CNT_W)
    ) u_cap (
        .region_first(region_first),
        .region_last (region_last),
        .capacity    (capacity)
    );

    seg_pointer #(
        .ADDR_W   (ADDR_W),
        .SEG_SHIFT(SEG_SHIFT),
        .CNT_W    (CNT_W)
    ) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .advance     (grant),
        .capacity    (capacity),
        .region_first(region_first),
        .seg_addr    (req_addr)
    );

    seg_occupancy #(
        .CNT_W(CNT_W)
    ) u_occ (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .take     (grant),
        .give_back(release_pulse),
        .capacity (capacity),
        .held     (occ_count),
        .full     (occ_full)
    );
endmodule

// File: rtl/seg_ring_alloc_chk.sv
module seg_ring_alloc_chk #(
    parameter int ADDR_W    = 28,
    parameter int SEG_BYTES = 2048,
    parameter int CNT_W     = ADDR_W + 1 - $clog2(SEG_BYTES)
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic [ADDR_W-1:0] region_first,
    input logic [ADDR_W-1:0] region_last,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              release_pulse,
    input logic [CNT_W-1:0]  occ_count,
    input logic [CNT_W-1:0]  capacity
);
    localparam int SEG_SHIFT = $clog2(SEG_BYTES);

    logic            grant_w;
    logic [ADDR_W:0] seg_end;
    logic [ADDR_W-1:0] rel_off;

    assign grant_w = req_valid && req_ready;
    assign seg_end = {1'b0, req_addr} + (ADDR_W+1)'(SEG_BYTES - 1);
    assign rel_off = req_addr - region_first;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !req_valid);

    // R4
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        (occ_count >= capacity) |-> !req_valid);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occ_count <= capacity);

    // R2
    grant_count_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_w && !release_pulse) |=> (occ_count == $past(occ_count) + CNT_W'(1)));

    // R6
    grant_release_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_w && release_pulse) |=> $stable(occ_count));

    // R9
    release_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !grant_w && release_pulse) |=> (!enable || $stable(req_addr)));

    // R3
    step_or_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        grant_w |=> (!enable || req_addr == region_first ||
                     req_addr == ADDR_W'($past(req_addr) + ADDR_W'(SEG_BYTES))));

    // R10
    in_window_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (seg_end <= {1'b0, region_last} && rel_off[SEG_SHIFT-1:0] == '0));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (occ_count == '0));
endmodule

bind seg_ring_alloc seg_ring_alloc_chk #(
    .ADDR_W   (ADDR_W),
    .SEG_BYTES(SEG_BYTES),
    .CNT_W    (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .region_first (region_first),
    .region_last  (region_last),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .release_pulse(release_pulse),
    .occ_count    (occ_count),
    .capacity     (capacity)
);

// File: tb/test_seg_ring_alloc.sv
module test_seg_ring_alloc;
    localparam int AW    = 16;
    localparam int SEG   = 64;
    localparam int NSEG  = 5;
    localparam logic [AW-1:0] FIRST = 16'h0100;
    localparam logic [AW-1:0] LAST  = FIRST + AW'(NSEG * SEG + 40 - 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic          req_ready = 1'b0;
    logic          release_pulse = 1'b0;
    logic          req_valid;
    logic [AW-1:0] req_addr;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];
    int            m_idx = 0;
    int            m_cnt = 0;

    always #4 clk = ~clk;

    seg_ring_alloc #(.ADDR_W(AW), .SEG_BYTES(SEG)) i_seg_ring_alloc (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .region_first (FIRST),
        .region_last  (LAST),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .release_pulse(release_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FIAL-free %s", tag) ;
        end
    endtask

    // Monitor: pops one expected address for every cycle the driver offers ready.
    always @(negedge clk) begin
        if (!finished && req_ready) begin
            logic [AW-1:0] e;
            string t;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
            t = (tag_q.size() > 0) ? tag_q.pop_front() : "R2";
            total++;
            if (!req_valid || req_addr !== e) begin
                bad++;
                $display("FAIL %s grant: actual valid=%0b addr=0x%0h expected addr=0x%0h",
                         t, req_valid, req_addr, e);
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic at_neg;
        @(negedge clk);
    endtask

    task automatic model_clear;
        m_idx = 0;
        m_cnt = 0;
    endtask

    task automatic push_grant(input string tag);
        exp_q.push_back(FIRST + AW'(m_idx * SEG));
        tag_q.push_back(tag);
        m_idx = (m_idx + 1 == NSEG) ? 0 : m_idx + 1;
    endtask

    task automatic do_grant(input string tag);
        push_grant(tag);
        m_cnt++;
        req_ready = 1'b1;
        tick();
        req_ready = 1'b0;
    endtask

    task automatic do_release;
        release_pulse = 1'b1;
        tick();
        release_pulse = 1'b0;
        m_cnt--;
    endtask

    task automatic do_both(input string tag);
        push_grant(tag);
        req_ready     = 1'b1;
        release_pulse = 1'b1;
        tick();
        req_ready     = 1'b0;
        release_pulse = 1'b0;
    endtask

    task automatic expect_valid(input logic exp, input string tag);
        at_neg();
        total++;
        if (req_valid !== exp) begin
            bad++;
            $display("FAIL %s valid: actual=%0b expected=%0b", tag, req_valid, exp);
        end
    endtask

    task automatic expect_addr(input logic [AW-1:0] exp, input string tag);
        at_neg();
        total++;
        if (req_addr !== exp) begin
            bad++;
            $display("FAIL %s addr: actual=0x%0h expected=0x%0h", tag, req_addr, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        enable = 1'b1;
        repeat (3) tick();
        expect_valid(1'b0, "R8 reset holds valid low");
        tick();
        rst    = 1'b0;
        enable = 1'b0;
        tick();
        expect_valid(1'b0, "R1 disabled");
        enable = 1'b1;
        model_clear();
        expect_valid(1'b1, "R1 offer on enable");
        expect_addr(FIRST, "R2 first address");
        tick();

        for (int i = 0; i < NSEG; i++) do_grant("R2");
        expect_valid(1'b0, "R4 full window");
        tick();

        do_release();
        expect_valid(1'b1, "R5 reopen after release");
        expect_addr(FIRST, "R3 wrap skips tail");
        tick();

        do_release();
        expect_addr(FIRST, "R9 release leaves address");
        tick();
        do_grant("R3");

        do_both("R6");
        expect_valid(1'b1, "R6 count unchanged");
        tick();
        do_grant("R2");
        expect_valid(1'b0, "R4 full again");
        tick();

        enable = 1'b0;
        tick();
        expect_valid(1'b0, "R1 enable dropped");
        enable = 1'b1;
        model_clear();
        expect_addr(FIRST, "R7 pointer cleared");
        tick();
        for (int i = 0; i < NSEG; i++) do_grant("R7");
        expect_valid(1'b0, "R7 count cleared gives full capacity");
        tick();

        do_release();
        do_release();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        model_clear();
        expect_valid(1'b1, "R8 count cleared by reset");
        expect_addr(FIRST, "R8 pointer cleared by reset");
        tick();
        do_grant("R8");
        do_grant("R8");
        tick();

        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R2 scoreboard: actual=%0d pending expected=0", exp_q.size());
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule